// File: doc/BRIEF.md
# Machine Control Register with Coprocessor Trap Check

This block holds the processor's 32-bit machine control word and decides, for every issued instruction, whether a coprocessor or wait instruction must be refused with the "coprocessor not available" exception. The word can change in four ways. A full load replaces the whole word. A short load writes only the four status bits at the bottom of the word. A hardware task-switch event marks the current coprocessor context as stale. An explicit clear operation marks it as valid again.

The execution pipeline presents one instruction class per cycle, qualified by a valid strobe. One cycle later the block raises a fault request with a fixed exception vector whenever the flags in force during the instruction's cycle forbid that instruction. The paging-enable and protection-enable bits are exported so that the paging and mode logic can follow the register.

Top module: `ctl_word_unit`

## Requirements
- R1: After reset `ctl_q` is zero, except bit 4, which takes the parameter `RSVD_RST` (default 0). `flt_req` is 0 and `flt_vec` is 0.
- R2: A full load (`full_we`=1) writes `full_wdata` into every bit of `ctl_q` at the next clock edge, except bit 4. Bit 4 keeps its value, and it never changes after reset. A full load can clear bit 0 (protection enable).
- R3: A short load (`low_we`=1 with `full_we`=0) writes `low_wdata[3:1]` into bits 3:1. Bit 0 becomes the OR of its old value and `low_wdata[0]`, so a short load can set protection enable but never clear it. Bits 31:4 are unchanged.
- R4: When `full_we` and `low_we` are both high in the same cycle, only the full load takes effect.
- R5: Bit 3 (task switched, TS) becomes 1 after a cycle with `task_sw`=1, and 0 after a cycle with `clr_ts`=1 and `task_sw`=0. These two operations override any load of bit 3 in the same cycle, and `task_sw` wins over `clr_ts`.
- R6: An instruction with `ins_vld`=1 and `ins_cls`=2'b01 (coprocessor escape) faults when bit 2 (emulate, EM) or TS is 1.
- R7: An instruction with `ins_vld`=1 and `ins_cls`=2'b10 (wait) faults only when both bit 1 (monitor, MP) and TS are 1. EM has no effect on it.
- R8: No fault is raised when `ins_vld`=0, or for class codes 2'b00 and 2'b11.
- R9: `flt_req` is a one-cycle pulse in the cycle after the faulting instruction. It is decided from the flags held in the instruction's own cycle, before any write in that cycle lands. `flt_vec` equals 7 while `flt_req` is 1 and 0 otherwise.
- R10: `page_en` always shows bit 31 of `ctl_q`, and `prot_en` always shows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_we | input | 1 | Full-word load strobe |
| full_wdata | input | 32 | Full-word load data |
| low_we | input | 1 | Short status-word load strobe |
| low_wdata | input | 4 | Short load data for bits 3:0 |
| task_sw | input | 1 | Task-switch event; sets TS |
| clr_ts | input | 1 | Clear-TS operation |
| ins_vld | input | 1 | Instruction class is valid this cycle |
| ins_cls | input | 2 | Class: 00 other, 01 escape, 10 wait, 11 other |
| ctl_q | output | 32 | Current control word |
| page_en | output | 1 | Paging enable (bit 31) |
| prot_en | output | 1 | Protection enable (bit 0) |
| flt_req | output | 1 | Coprocessor-not-available fault request |
| flt_vec | output | 8 | Exception vector, 7 while requested |

## Verification
The assertions run on every cycle. They check that bit 4 stays frozen, that a short load never drops protection enable and never touches the upper bits, that a task switch always leaves TS set, and that the escape and wait fault decisions agree with the flags of the previous cycle. Some behaviour only the bench scenarios can show. These are the full sweep of EM, MP and TS against both instruction classes, the priority of a full load over a short load, the same-cycle collision of task switch and clear, and the use of the old flags when an instruction and a write arrive together. The bench also checks the exact value of the whole word after long random runs of mixed writes.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
   typedef enum logic [1:0] {
      CLS_NONE = 2'b00,
      CLS_ESC  = 2'b01,
      CLS_WAIT = 2'b10,
      CLS_RSV  = 2'b11
   } ins_cls_e;

   localparam int PE_B  = 0;
   localparam int MP_B  = 1;
   localparam int EM_B  = 2;
   localparam int TS_B  = 3;
   localparam int RSV_B = 4;
   localparam int LOW_W = 4;
endpackage

// File: rtl/ctlw_store.sv
module ctlw_store
   import ctlw_pkg::*;
#(
   parameter int CR_W     = 32,
   parameter bit RSVD_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             full_we,
   input  logic [CR_W-1:0]  full_wdata,
   input  logic             low_we,
   input  logic [LOW_W-1:0] low_wdata,
   input  logic             task_sw,
   input  logic             clr_ts,
   output logic [CR_W-1:0]  q
);
   localparam logic [CR_W-1:0] RST_VAL = {{(CR_W-RSV_B-1){1'b0}}, RSVD_RST, {RSV_B{1'b0}}};

   logic [CR_W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (full_we) begin
         nxt        = full_wdata;
         nxt[RSV_B] = q[RSV_B];
      end else if (low_we) begin
         nxt[TS_B:MP_B] = low_wdata[TS_B:MP_B];
         nxt[PE_B]      = q[PE_B] | low_wdata[PE_B];
      end
      if (task_sw)
         nxt[TS_B] = 1'b1;
      else if (clr_ts)
         nxt[TS_B] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/ctlw_trap.sv
module ctlw_trap
   import ctlw_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int FLT_VEC   = 7,
   parameter bit REG_FAULT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             em,
   input  logic             mp,
   input  logic             ts,
   input  logic             ins_vld,
   input  logic [1:0]       ins_cls,
   output logic             flt_req,
   output logic [VEC_W-1:0] flt_vec
);
   localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FLT_VEC);

   ins_cls_e cls;
   logic     hit;

   always_comb begin
      cls = ins_cls_e'(ins_cls);
      hit = 1'b0;
      if (ins_vld) begin
         unique case (cls)
            CLS_ESC:  hit = em | ts;
            CLS_WAIT: hit = mp & ts;
            default:  hit = 1'b0;
         endcase
      end
   end

   generate
      if (REG_FAULT) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= hit;
         end
         assign flt_req = hit_q;
      end else begin : g_comb
         assign flt_req = hit;
      end
   endgenerate

   assign flt_vec = flt_req ? VEC_VAL : '0;
endmodule

// File: rtl/ctl_word_unit.sv
module ctl_word_unit
   import ctlw_pkg::*;
#(
   parameter int CR_W      = 32,
   parameter int VEC_W     = 8,
   parameter int FLT_VEC   = 7,
   parameter bit RSVD_RST  = 1'b0,
   parameter bit REG_FAULT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             full_we,
   input  logic [CR_W-1:0]  full_wdata,
   input  logic             low_we,
   input  logic [3:0]       low_wdata,
   input  logic             task_sw,
   input  logic             clr_ts,
   input  logic             ins_vld,
   input  logic [1:0]       ins_cls,
   output logic [CR_W-1:0]  ctl_q,
   output logic             page_en,
   output logic             prot_en,
   output logic             flt_req,
   output logic [VEC_W-1:0] flt_vec
);
   localparam int PG_B = CR_W - 1;

   generate
      if (CR_W < RSV_B + 2) begin : g_bad_w
         $error("ctl_word_unit: CR_W too small for flag layout");
      end
      if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vw
         $error("ctl_word_unit: VEC_W out of range");
      end
      if (FLT_VEC < 0 || FLT_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("ctl_word_unit: FLT_VEC does not fit VEC_W");
      end
   endgenerate

   ctlw_store #(.CR_W(CR_W), .RSVD_RST(RSVD_RST)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .full_we    (full_we),
      .full_wdata (full_wdata),
      .low_we     (low_we),
      .low_wdata  (low_wdata),
      .task_sw    (task_sw),
      .clr_ts     (clr_ts),
      .q          (ctl_q)
   );

   ctlw_trap #(.VEC_W(VEC_W), .FLT_VEC(FLT_VEC), .REG_FAULT(REG_FAULT)) u_trap (
      .clk     (clk),
      .rst_n   (rst_n),
      .em      (ctl_q[EM_B]),
      .mp      (ctl_q[MP_B]),
      .ts      (ctl_q[TS_B]),
      .ins_vld (ins_vld),
      .ins_cls (ins_cls),
      .flt_req (flt_req),
      .flt_vec (flt_vec)
   );

   assign page_en = ctl_q[PG_B];
   assign prot_en = ctl_q[PE_B];
endmodule

// File: rtl/ctlw_chk.sv
module ctlw_chk
   import ctlw_pkg::*;
#(
   parameter int CR_W      = 32,
   parameter int VEC_W     = 8,
   parameter int FLT_VEC   = 7,
   parameter bit REG_FAULT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             full_we,
   input logic             low_we,
   input logic             task_sw,
   input logic             ins_vld,
   input logic [1:0]       ins_cls,
   input logic [CR_W-1:0]  ctl_q,
   input logic             flt_req,
   input logic [VEC_W-1:0] flt_vec
);
   AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ctl_q[RSV_B])); // R2
   AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (low_we && !full_we && ctl_q[PE_B]) |=> ctl_q[PE_B]); // R3
   AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (low_we && !full_we) |=> (ctl_q[CR_W-1:RSV_B] == $past(ctl_q[CR_W-1:RSV_B]))); // R3
   AST_TS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      task_sw |=> ctl_q[TS_B]); // R5
   AST_VEC_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      flt_req |-> (flt_vec == VEC_W'(FLT_VEC))); // R9

   generate
      if (REG_FAULT) begin : g_reg_chk
         AST_ESC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_vld && ins_cls == CLS_ESC && (ctl_q[EM_B] || ctl_q[TS_B])) |=> flt_req); // R6
         AST_WAIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_vld && ins_cls == CLS_WAIT) |=> (flt_req == ($past(ctl_q[MP_B]) && $past(ctl_q[TS_B])))); // R7
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!ins_vld || ins_cls == CLS_NONE || ins_cls == CLS_RSV) |=> !flt_req); // R8
      end else begin : g_comb_chk
         AST_ESC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_vld && ins_cls == CLS_ESC && (ctl_q[EM_B] || ctl_q[TS_B])) |-> flt_req); // R6
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !ins_vld |-> !flt_req); // R8
      end
   endgenerate
endmodule

bind ctl_word_unit ctlw_chk #(
   .CR_W(CR_W), .VEC_W(VEC_W), .FLT_VEC(FLT_VEC), .REG_FAULT(REG_FAULT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .full_we (full_we),
   .low_we  (low_we),
   .task_sw (task_sw),
   .ins_vld (ins_vld),
   .ins_cls (ins_cls),
   .ctl_q   (ctl_q),
   .flt_req (flt_req),
   .flt_vec (flt_vec)
);

// File: tb/sim_ctl_word_unit.sv
`timescale 1ns/1ps
module sim_ctl_word_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_we = 1'b0;
   logic [31:0] full_wdata = '0;
   logic        low_we = 1'b0;
   logic [3:0]  low_wdata = '0;
   logic        task_sw = 1'b0;
   logic        clr_ts = 1'b0;
   logic        ins_vld = 1'b0;
   logic [1:0]  ins_cls = '0;
   logic [31:0] ctl_q;
   logic        page_en, prot_en, flt_req;
   logic [7:0]  flt_vec;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] m_q = '0;

   always #5 clk = ~clk;

   ctl_word_unit u0 (
      .clk(clk), .rst_n(rst_n), .full_we(full_we), .full_wdata(full_wdata),
      .low_we(low_we), .low_wdata(low_wdata), .task_sw(task_sw), .clr_ts(clr_ts),
      .ins_vld(ins_vld), .ins_cls(ins_cls), .ctl_q(ctl_q), .page_en(page_en),
      .prot_en(prot_en), .flt_req(flt_req), .flt_vec(flt_vec)
   );

   function automatic logic [31:0] next_q(logic [31:0] q, logic fw, logic [31:0] fd,
                                          logic lw, logic [3:0] ld, logic ts, logic clr);
      logic [31:0] n = q;
      if (fw) n = {fd[31:5], q[4], fd[3:0]};
      else if (lw) n = {q[31:4], ld[3:1], q[0] | ld[0]};
      if (ts) n[3] = 1'b1;
      else if (clr) n[3] = 1'b0;
      return n;
   endfunction

   function automatic logic exp_fault(logic [31:0] q, logic vld, logic [1:0] cls);
      if (!vld) return 1'b0;
      if (cls == 2'b01) return q[2] | q[3];
      if (cls == 2'b10) return q[1] & q[3];
      return 1'b0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(logic fw, logic [31:0] fd, logic lw, logic [3:0] ld,
                       logic ts, logic clr, logic vld, logic [1:0] cls, string tag);
      logic ef;
      string ftag;
      full_we = fw; full_wdata = fd; low_we = lw; low_wdata = ld;
      task_sw = ts; clr_ts = clr; ins_vld = vld; ins_cls = cls;
      ef = exp_fault(m_q, vld, cls);
      m_q = next_q(m_q, fw, fd, lw, ld, ts, clr);
      @(posedge clk);
      @(negedge clk);
      full_we = 1'b0; low_we = 1'b0; task_sw = 1'b0; clr_ts = 1'b0; ins_vld = 1'b0;
      ftag = (vld && cls == 2'b01) ? "R6" : (vld && cls == 2'b10) ? "R7" : "R8";
      chk(tag, ctl_q, m_q);
      chk(ftag, {31'b0, flt_req}, {31'b0, ef});
      chk("R9", {24'b0, flt_vec}, ef ? 32'd7 : 32'd0);
      chk("R10", {30'b0, page_en, prot_en}, {30'b0, m_q[31], m_q[0]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk("R1", ctl_q, 32'h0);
      chk("R1", {31'b0, flt_req}, 32'd0);
      chk("R1", {24'b0, flt_vec}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: full load with reserved bit set, reserved bit stays 0
      step(1, 32'h8000_001F, 0, 4'h0, 0, 0, 0, 2'b00, "R2");
      // R3: short load tries to clear PE, PE stays 1, TS/EM/MP rewritten
      step(0, 32'h0, 1, 4'b1010, 0, 0, 0, 2'b00, "R3");
      chk("R3", {31'b0, prot_en}, 32'd1);
      // R2: full load clears PE
      step(1, 32'h0000_0000, 0, 4'h0, 0, 0, 0, 2'b00, "R2");
      // R3: short load sets PE from zero
      step(0, 32'h0, 1, 4'b0001, 0, 0, 0, 2'b00, "R3");
      // R4: both loads, full load wins
      step(1, 32'h1234_5000, 1, 4'b1111, 0, 0, 0, 2'b00, "R4");
      // R5: task switch and clear together, task switch wins
      step(0, 32'h0, 0, 4'h0, 1, 1, 0, 2'b00, "R5");
      step(0, 32'h0, 0, 4'h0, 0, 1, 0, 2'b00, "R5");
      // R5: task switch overrides full load writing TS=0
      step(1, 32'h0000_0000, 0, 4'h0, 1, 0, 0, 2'b00, "R5");
      // R9: instruction sees old TS when a clear lands in the same cycle
      step(0, 32'h0, 0, 4'h0, 0, 1, 1, 2'b01, "R9");
      step(0, 32'h0, 0, 4'h0, 0, 0, 0, 2'b00, "R9");

      // R6 / R7: every EM, MP, TS combination against escape and wait
      for (int f = 0; f < 8; f++) begin
         for (int c = 1; c < 3; c++) begin
            step(1, {28'h0, f[2], f[0], f[1], 1'b1}, 0, 4'h0, 0, 0, 0, 2'b00, "R2");
            step(0, 32'h0, 0, 4'h0, 0, 0, 1, 2'(c), (c == 1) ? "R6" : "R7");
         end
      end
      // R8: classes 00 and 11 and invalid strobe never fault with all flags set
      step(1, 32'h0000_000F, 0, 4'h0, 0, 0, 0, 2'b00, "R8");
      step(0, 32'h0, 0, 4'h0, 0, 0, 1, 2'b00, "R8");
      step(0, 32'h0, 0, 4'h0, 0, 0, 1, 2'b11, "R8");
      step(0, 32'h0, 0, 4'h0, 0, 0, 0, 2'b01, "R8");

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic fw = ($urandom % 8) == 0;
         logic lw = ($urandom % 6) == 0;
         step(fw, $urandom, lw, 4'($urandom), ($urandom % 7) == 0, ($urandom % 5) == 0,
              ($urandom % 3) != 0, 2'($urandom), "R2");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule